// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of a pipelined synchronous memory and turns one starting address into a four-beat sequence of addresses. A load cycle captures the complete address and the type of access, read or write. Each following advance cycle moves the two lowest address bits one step further. The upper address bits stay as they were. A static order input picks the sequence. In linear order the beat count is added to the starting low bits. In interleaved order the beat count is XORed into them.

The controller issues one load and then up to three advances to cover an aligned group of four words. If it keeps advancing, the sequence wraps back to the starting word. Advance cycles do not look at the bank selects or at the write strobe, so the access type chosen at load time applies to the whole burst. A load cycle with the bank deselected clears the valid flag. Only a later load with the bank selected sets it again. While the clock-enable input is high, all state is frozen.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high and just after it is released, `addr_out` is 0, `valid` is 0 and `acc_wr` is 0.
- R2: A load cycle is a clock edge with `clk_en_n`=0, `adv_ld`=0 and all three selects active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0). After it, `addr_out` equals the `addr_in` sampled at that edge and `valid` is 1.
- R3: A load cycle sets `acc_wr` to the inverse of the sampled `wr_n` (1 means write). Advance cycles leave `acc_wr` unchanged.
- R4: With `order_il`=0 (linear), after n advances since the load, `addr_out[1:0]` equals (start[1:0] + n) mod 4.
- R5: With `order_il`=1 (interleaved), after n advances since the load, `addr_out[1:0]` equals start[1:0] XOR (n mod 4). For example, a start of 01 gives 01, 00, 11, 10.
- R6: An advance cycle (`clk_en_n`=0, `adv_ld`=1) never changes `addr_out[ADDR_W-1:2]`.
- R7: An advance cycle steps the sequence whatever the values of the three selects and of `wr_n`.
- R8: An edge with `clk_en_n`=1 changes none of `addr_out`, `acc_wr` and `valid`, whatever the other inputs are.
- R9: A cycle with `clk_en_n`=0, `adv_ld`=0 and any select inactive clears `valid`. Advance cycles never change `valid`.
- R10: After four advances, `addr_out` again equals the start address. Advancing further continues the same cycle and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high holds all state |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| sel_a_n | input | 1 | Bank select A, active low |
| sel_b | input | 1 | Bank select B, active high |
| sel_c_n | input | 1 | Bank select C, active low |
| wr_n | input | 1 | Write strobe, active low, sampled on load |
| addr_in | input | ADDR_W | Starting address |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current burst address |
| acc_wr | output | 1 | Latched access type, 1 = write |
| valid | output | 1 | Burst selected and active |

## Verification
The bench builds the block with `ADDR_W`=6. With that width it can load every one of the 64 start addresses in both orders and with both access types. Each burst runs six advances, so the wrap after four beats and the step past it are checked from every start offset. The bench computes the expected low bits by addition or XOR and compares the upper bits with the loaded value. While doing so it toggles the selects and the write strobe during advances and inserts a held cycle, so that the ignore and hold rules are checked against every start address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Number of low address bits that take part in a burst.
    localparam int unsigned BEAT_W   = 2;
    localparam int unsigned BEAT_CNT = 1 << BEAT_W;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_DESEL = 2'd2,
        CMD_STEP  = 2'd3
    } cmd_e;

    // Low-bit offset of one beat for the chosen order.
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input order_e            ord
    );
        logic [BEAT_W-1:0] r;
        if (ord == ORD_INTERLEAVE) r = start ^ beat;
        else                       r = start + beat;
        return r;
    endfunction

    // All three bank selects active.
    function automatic logic bank_selected(
        input logic a_n,
        input logic b,
        input logic c_n
    );
        return (!a_n) && b && (!c_n);
    endfunction

endpackage

// File: rtl/bsq_cmd_decode.sv
module bsq_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic clk_en_n,
    input  logic adv_ld,
    input  logic sel_a_n,
    input  logic sel_b,
    input  logic sel_c_n,
    output cmd_e cmd
);

    always_comb begin
        if (clk_en_n)                              cmd = CMD_HOLD;
        else if (adv_ld)                           cmd = CMD_STEP;
        else if (bank_selected(sel_a_n, sel_b, sel_c_n)) cmd = CMD_LOAD;
        else                                       cmd = CMD_DESEL;
    end

endmodule

// File: rtl/bsq_beat_cnt.sv
module bsq_beat_cnt
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    output logic [BEAT_W-1:0] beat
);

    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: beat_q <= '0;
                CMD_STEP: beat_q <= beat_q + 1'b1;   // wraps modulo BEAT_CNT
                default:  beat_q <= beat_q;
            endcase
        end
    end

    assign beat = beat_q;

endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
)(
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_il,
    output logic [ADDR_W-1:0] addr
);

    localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

    order_e            ord;
    logic [BEAT_W-1:0] low;

    assign ord = order_e'(order_il);
    assign low = beat_low(base[BEAT_W-1:0], beat, ord);

    generate
        if (UPPER_W > 0) begin : g_upper
            assign addr = {base[ADDR_W-1:BEAT_W], low};
        end else begin : g_low_only
            assign addr = low;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              adv_ld,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_il,
    output logic [ADDR_W-1:0] addr_out,
    output logic              acc_wr,
    output logic              valid
);

    cmd_e              cmd;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base_q;
    acc_e              acc_q;
    logic              valid_q;

    bsq_cmd_decode u_dec (
        .clk_en_n (clk_en_n),
        .adv_ld   (adv_ld),
        .sel_a_n  (sel_a_n),
        .sel_b    (sel_b),
        .sel_c_n  (sel_c_n),
        .cmd      (cmd)
    );

    bsq_beat_cnt u_cnt (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .beat (beat)
    );

    // Start address, access type and valid flag change only on load-type cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            acc_q   <= ACC_READ;
            valid_q <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    base_q  <= addr_in;
                    acc_q   <= wr_n ? ACC_READ : ACC_WRITE;
                    valid_q <= 1'b1;
                end
                CMD_DESEL: valid_q <= 1'b0;
                default: ;
            endcase
        end
    end

    bsq_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
        .base     (base_q),
        .beat     (beat),
        .order_il (order_il),
        .addr     (addr_out)
    );

    assign acc_wr = (acc_q == ACC_WRITE);
    assign valid  = valid_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int unsigned ADDR_W = 17
)(
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              adv_ld,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              order_il,
    input logic [ADDR_W-1:0] addr_out,
    input logic              acc_wr,
    input logic              valid
);

    logic sel_ok;
    logic step;
    logic ld;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
    assign step   = !clk_en_n && adv_ld;
    assign ld     = !clk_en_n && !adv_ld;

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (ld && sel_ok) |=> (valid && addr_out == $past(addr_in)));

    // R3
    acc_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ld && sel_ok) |=> (acc_wr == !$past(wr_n)));

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(acc_wr));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !order_il) |=> (!order_il ->
            addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

    // R6
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(acc_wr) && $stable(valid) &&
                      ($stable(order_il) -> $stable(addr_out))));

    // R9
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        (ld && !sel_ok) |=> !valid);

    // R9
    step_valid_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(valid));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en_n (clk_en_n),
    .adv_ld   (adv_ld),
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .wr_n     (wr_n),
    .addr_in  (addr_in),
    .order_il (order_il),
    .addr_out (addr_out),
    .acc_wr   (acc_wr),
    .valid    (valid)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

    localparam int unsigned AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b1;
    logic          adv_ld = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          order_il = 1'b0;
    logic [AW-1:0] addr_out;
    logic          acc_wr;
    logic          valid;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
        .addr_in(addr_in), .order_il(order_il),
        .addr_out(addr_out), .acc_wr(acc_wr), .valid(valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one cycle of inputs, then sample 1 ns after the edge.
    task automatic cyc(input logic en_n, input logic adv, input logic a_n,
                       input logic b, input logic c_n, input logic w_n,
                       input int a);
        clk_en_n = en_n; adv_ld = adv; sel_a_n = a_n; sel_b = b;
        sel_c_n = c_n; wr_n = w_n; addr_in = AW'(a);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: state while reset is held
        check("R1 addr", int'(addr_out), 0);
        check("R1 valid", int'(valid), 0);
        check("R1 acc", int'(acc_wr), 0);
        rst = 1'b0;
        cyc(1, 0, 0, 1, 0, 1, 0);
        check("R1 addr after release", int'(addr_out), 0);
        check("R1 valid after release", int'(valid), 0);

        for (int ord = 0; ord < 2; ord++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < (1 << AW); s++) begin
                    int exp_low;
                    int beat;
                    order_il = ord[0];
                    cyc(0, 0, 0, 1, 0, ~w[0], s);
                    check("R2 load addr", int'(addr_out), s);
                    check("R2 load valid", int'(valid), 1);
                    check("R3 load type", int'(acc_wr), w);
                    beat = 0;
                    for (int k = 1; k <= 6; k++) begin
                        if (k == 3) begin
                            // R8: clock enable high, other inputs would load
                            cyc(1, 0, 0, 1, 0, w[0], s ^ 21);
                            exp_low = (ord != 0) ? ((s & 3) ^ beat) : ((s + beat) & 3);
                            check("R8 hold addr", int'(addr_out), (s & ~3) | exp_low);
                            check("R8 hold valid", int'(valid), 1);
                            check("R8 hold type", int'(acc_wr), w);
                        end
                        // R7: odd beats advance with all selects inactive,
                        // and wr_n is driven to the opposite access type
                        if (k % 2 == 1) cyc(0, 1, 1, 0, 1, w[0], ~s);
                        else            cyc(0, 1, 0, 1, 0, w[0], ~s);
                        beat = k & 3;
                        exp_low = (ord != 0) ? ((s & 3) ^ beat) : ((s + beat) & 3);
                        check((ord != 0) ? "R5 R7 interleave low" : "R4 R7 linear low",
                              int'(addr_out[1:0]), exp_low);
                        check("R6 upper", int'(addr_out[AW-1:2]), s >> 2);
                        check("R3 type kept", int'(acc_wr), w);
                        check("R9 valid kept on advance", int'(valid), 1);
                        if (k == 4) check("R10 wrap", int'(addr_out), s);
                    end
                end
            end
        end

        // R9: each select inactive in turn
        order_il = 1'b0;
        for (int v = 0; v < 3; v++) begin
            cyc(0, 0, 0, 1, 0, 1, 9);
            check("R9 reload valid", int'(valid), 1);
            cyc(0, 0, (v == 0), (v != 1), (v == 2), 1, 40);
            check("R9 deselect clears", int'(valid), 0);
            check("R9 deselect keeps addr", int'(addr_out), 9);
            cyc(0, 1, 0, 1, 0, 0, 40);
            check("R9 advance leaves clear", int'(valid), 0);
            check("R7 advance after deselect steps", int'(addr_out), 10);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule